// File: doc/BRIEF.md
# I2C Bus-Stuck Recovery Sequencer

This block sits beside an I2C controller and watches its bus-busy status. When a caller asks to start a transfer, the sequencer waits for the bus to become free, counting ticks from a slow timebase. If the bus is still held when the wait limit runs out, it raises a one-cycle timeout error and adds a strike. The first few strikes are only reported. Once the strike count has gone past its limit, the next wait that finds the bus busy clears the count and runs a hardware recovery instead of reporting again.

Recovery first asks the controller to stop acknowledging, with the NACK-mode request. It then moves the SCL pad from the controller to a manual driver. The manual driver toggles SCL through a fixed number of pulses, and each pulse has a high phase and a low phase of equal length. At the end the pad goes back to the controller, and a one-cycle soft-reset pulse tells the controller to restart and reload its settings. A separate strobe, raised when a transfer did not finish in time, starts the same recovery at once. Phase lengths are given in microseconds and turned into clock cycles from the system clock frequency. The wait limit is counted in timebase ticks, so about one second comes from a 1 kHz tick and a limit of 1000.

Top module: `i2c_unstick_seq`

## Requirements
- R1: While and after reset, the outputs are: `scl_manual_sel`=0, `scl_level`=1, `nack_mode`=0, `ctrl_reset`=0, `tmo_err`=0, `done`=0.
- R2: When `wait_req` is pulsed and `bus_busy` is low, or goes low before the wait limit, the block returns to idle. It raises no error and starts no recovery.
- R3: If `bus_busy` stays high for `WAIT_TICKS` ticks after `wait_req`, `tmo_err` is high for exactly one cycle, appearing the cycle after the tick that completed the count, and one strike is added.
- R4: The first `STRIKE_LIMIT`+1 timeouts only report. After that, a wait that finds `bus_busy` high starts recovery on the next clock and clears the strike count, so the following timeout only reports again.
- R5: Recovery opens with one cycle in which `nack_mode` is 1 and `scl_manual_sel` is 0. `nack_mode` then stays 1 for as long as `scl_manual_sel` is 1.
- R6: While `scl_manual_sel` is 1, `scl_level` makes exactly `NUM_PULSES` pulses. Each pulse is `PHASE_CYCLES` cycles at 1 followed by `PHASE_CYCLES` cycles at 0. When `scl_manual_sel` is 0, `scl_level` is 1.
- R7: The cycle after the last low phase has `scl_manual_sel`=0, `nack_mode`=0, `ctrl_reset`=1 and `done`=1. Both pulses last one cycle, and the block is idle afterwards.
- R8: A `xfer_tmo` strobe in idle or during a wait starts recovery on the next clock without reporting an error, and it leaves the strike count unchanged.
- R9: `wait_req` and `xfer_tmo` are ignored while recovery runs. After recovery the block stays idle and reports nothing, even with the bus busy.
- R10: `PHASE_CYCLES` equals `CLK_HZ`*`PHASE_US`/1,000,000 rounded down, with a minimum of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_busy | input | 1 | Bus-busy status from the I2C controller |
| wait_req | input | 1 | Strobe: a transfer wants the bus, start the busy wait |
| xfer_tmo | input | 1 | Strobe: a transfer missed its completion deadline |
| tick | input | 1 | One-cycle strobe from the timebase that paces the wait limit |
| scl_manual_sel | output | 1 | SCL pad select: 1 = manual driver (as output), 0 = controller |
| scl_level | output | 1 | Level driven on SCL by the manual driver |
| nack_mode | output | 1 | Request that the controller send NACK to the slave |
| ctrl_reset | output | 1 | One-cycle controller reset and reconfigure request |
| tmo_err | output | 1 | One-cycle wait-timeout error |
| done | output | 1 | One-cycle end-of-recovery marker |

## Verification
The bench builds the block with `CLK_HZ`=200000 and `PHASE_US`=25, which gives 5-cycle phases, together with `WAIT_TICKS`=4 and a tick every third cycle. These values keep the default pulse count of 10 and strike limit of 2. A full recovery then takes 102 cycles and a wait timeout about a dozen. This puts the whole escalation ladder within a short run: three reported timeouts, recovery, the reset of the strike count, and transfer-timeout recoveries both from idle and during a wait.

// File: rtl/i2c_unstick_pkg.sv
package i2c_unstick_pkg;

    typedef enum logic [2:0] {
        UNS_IDLE,
        UNS_WAIT,
        UNS_NACK,
        UNS_CLOCK,
        UNS_RESET
    } uns_state_e;

    typedef struct packed {
        logic manual;
        logic level;
        logic nack;
        logic reset;
    } pad_ctrl_t;

    // Clock cycles in one phase of the given length in microseconds, at least 1.
    function automatic int unsigned phase_cycles(longint unsigned clk_hz, longint unsigned us);
        longint unsigned c;
        c = (clk_hz * us) / 64'd1_000_000;
        if (c == 0) return 1;
        return int'(c);
    endfunction

endpackage

// File: rtl/unstick_wait_timer.sv
module unstick_wait_timer #(
    parameter int unsigned WAIT_TICKS = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic armed,
    input  logic busy,
    input  logic tick,
    output logic expire
);
    localparam int unsigned TW = $clog2(WAIT_TICKS + 1);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !armed)
            cnt <= '0;
        else if (busy && tick)
            cnt <= cnt + 1'b1;
    end

    assign expire = armed && busy && tick && (cnt == TW'(WAIT_TICKS - 1));
endmodule

// File: rtl/unstick_strikes.sv
module unstick_strikes #(
    parameter int unsigned LIMIT = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic bump,
    input  logic clear,
    output logic over
);
    localparam int unsigned SW = $clog2(LIMIT + 2);

    logic [SW-1:0] n;

    assign over = (n > SW'(LIMIT));

    always_ff @(posedge clk) begin
        if (rst || clear)
            n <= '0;
        else if (bump && !over)
            n <= n + 1'b1;
    end
endmodule

// File: rtl/unstick_pulser.sv
module unstick_pulser #(
    parameter int unsigned PHASE  = 5,
    parameter int unsigned PULSES = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic level,
    output logic last
);
    localparam int unsigned PW = $clog2(PHASE + 1);
    localparam int unsigned NW = $clog2(PULSES + 1);

    logic          active;
    logic [PW-1:0] ph_cnt;
    logic [NW-1:0] pl_cnt;
    logic          ph_end;

    assign ph_end = (ph_cnt == PW'(PHASE - 1));
    assign last   = active && !level && ph_end && (pl_cnt == NW'(PULSES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            level  <= 1'b1;
            ph_cnt <= '0;
            pl_cnt <= '0;
        end else if (start) begin
            active <= 1'b1;
            level  <= 1'b1;
            ph_cnt <= '0;
            pl_cnt <= '0;
        end else if (active) begin
            if (ph_end) begin
                ph_cnt <= '0;
                if (level) begin
                    level <= 1'b0;
                end else if (last) begin
                    active <= 1'b0;
                    level  <= 1'b1;
                end else begin
                    pl_cnt <= pl_cnt + 1'b1;
                    level  <= 1'b1;
                end
            end else begin
                ph_cnt <= ph_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/i2c_unstick_seq.sv
module i2c_unstick_seq
    import i2c_unstick_pkg::*;
#(
    parameter int unsigned CLK_HZ       = 27_000_000,
    parameter int unsigned PHASE_US     = 25,
    parameter int unsigned WAIT_TICKS   = 1000,
    parameter int unsigned NUM_PULSES   = 10,
    parameter int unsigned STRIKE_LIMIT = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic bus_busy,
    input  logic wait_req,
    input  logic xfer_tmo,
    input  logic tick,
    output logic scl_manual_sel,
    output logic scl_level,
    output logic nack_mode,
    output logic ctrl_reset,
    output logic tmo_err,
    output logic done
);
    localparam int unsigned PHASE_CYCLES = phase_cycles(64'(CLK_HZ), 64'(PHASE_US));

    uns_state_e state, state_nxt;
    logic       expire, over, bump, clear, start, last, pulse_lvl;
    pad_ctrl_t  pad;

    unstick_wait_timer #(.WAIT_TICKS(WAIT_TICKS)) timer_i (
        .clk(clk), .rst(rst), .armed(state == UNS_WAIT),
        .busy(bus_busy), .tick(tick), .expire(expire)
    );

    unstick_strikes #(.LIMIT(STRIKE_LIMIT)) strikes_i (
        .clk(clk), .rst(rst), .bump(bump), .clear(clear), .over(over)
    );

    unstick_pulser #(.PHASE(PHASE_CYCLES), .PULSES(NUM_PULSES)) pulser_i (
        .clk(clk), .rst(rst), .start(start), .level(pulse_lvl), .last(last)
    );

    always_comb begin
        state_nxt = state;
        bump      = 1'b0;
        clear     = 1'b0;
        start     = 1'b0;
        unique case (state)
            UNS_IDLE: begin
                if (xfer_tmo)      state_nxt = UNS_NACK;
                else if (wait_req) state_nxt = UNS_WAIT;
            end
            UNS_WAIT: begin
                if (xfer_tmo)       state_nxt = UNS_NACK;
                else if (!bus_busy) state_nxt = UNS_IDLE;
                else if (over) begin
                    state_nxt = UNS_NACK;
                    clear     = 1'b1;
                end else if (expire) begin
                    state_nxt = UNS_IDLE;
                    bump      = 1'b1;
                end
            end
            UNS_NACK: begin
                start     = 1'b1;
                state_nxt = UNS_CLOCK;
            end
            UNS_CLOCK: if (last) state_nxt = UNS_RESET;
            UNS_RESET: state_nxt = UNS_IDLE;
            default:   state_nxt = UNS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= UNS_IDLE;
            tmo_err <= 1'b0;
        end else begin
            state   <= state_nxt;
            tmo_err <= bump;
        end
    end

    always_comb begin
        pad.manual = (state == UNS_CLOCK);
        pad.level  = pad.manual ? pulse_lvl : 1'b1;
        pad.nack   = (state == UNS_NACK) || (state == UNS_CLOCK);
        pad.reset  = (state == UNS_RESET);
    end

    assign scl_manual_sel = pad.manual;
    assign scl_level      = pad.level;
    assign nack_mode      = pad.nack;
    assign ctrl_reset     = pad.reset;
    assign done           = pad.reset;
endmodule

// File: rtl/i2c_unstick_chk.sv
module i2c_unstick_chk #(
    parameter int unsigned PHASE = 5
) (
    input logic clk,
    input logic rst,
    input logic scl_manual_sel,
    input logic scl_level,
    input logic nack_mode,
    input logic ctrl_reset,
    input logic tmo_err,
    input logic done
);
    logic [31:0] run_q;
    logic        lvl_q, man_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
            lvl_q <= 1'b1;
            man_q <= 1'b0;
        end else begin
            if (scl_manual_sel)
                run_q <= (man_q && scl_level == lvl_q) ? run_q + 1 : 32'd1;
            else
                run_q <= '0;
            lvl_q <= scl_level;
            man_q <= scl_manual_sel;
        end
    end

    // R5
    nack_lead_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(scl_manual_sel) |-> $past(nack_mode) && !$past(scl_manual_sel));
    // R5
    nack_hold_chk: assert property (@(posedge clk) disable iff (rst)
        scl_manual_sel |-> nack_mode);
    // R6
    scl_idle_high_chk: assert property (@(posedge clk) disable iff (rst)
        !scl_manual_sel |-> scl_level);
    // R6
    phase_len_chk: assert property (@(posedge clk) disable iff (rst)
        (scl_manual_sel && man_q && scl_level == lvl_q) |-> run_q < PHASE);
    // R7
    reset_after_clock_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_reset |-> $past(scl_manual_sel) && done && !nack_mode && !scl_manual_sel);
    // R7
    reset_single_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl_reset |=> !ctrl_reset && !done);
    // R3
    err_single_chk: assert property (@(posedge clk) disable iff (rst)
        tmo_err |=> !tmo_err);
    // R3
    err_no_recover_chk: assert property (@(posedge clk) disable iff (rst)
        tmo_err |-> !nack_mode && !scl_manual_sel);
endmodule

bind i2c_unstick_seq i2c_unstick_chk #(.PHASE(PHASE_CYCLES)) chk_i (
    .clk(clk), .rst(rst), .scl_manual_sel(scl_manual_sel), .scl_level(scl_level),
    .nack_mode(nack_mode), .ctrl_reset(ctrl_reset), .tmo_err(tmo_err), .done(done)
);

// File: tb/i2c_unstick_seq_tb_top.sv
module i2c_unstick_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int P   = 5;
    localparam int N   = 10;
    localparam int WT  = 4;
    localparam int LIM = 2;
    localparam int REC_LAST = 2 * P * N + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_busy = 1'b0, wait_req = 1'b0, xfer_tmo = 1'b0, tick = 1'b0;
    logic scl_manual_sel, scl_level, nack_mode, ctrl_reset, tmo_err, done;

    i2c_unstick_seq #(
        .CLK_HZ(200_000), .PHASE_US(25), .WAIT_TICKS(WT),
        .NUM_PULSES(N), .STRIKE_LIMIT(LIM)
    ) dut_i (.*);

    always #(CLK_PERIOD / 2) clk = ~clk;

    int checks = 0, errors = 0;
    string tag = "R1";
    bit started = 0;

    // reference model
    int m_st = 0, m_ticks = 0, m_strikes = 0, m_rt = 0;
    bit m_err = 0;
    int tick_div = 0;

    always @(posedge clk) begin
        bit err_n;
        err_n = 0;
        if (rst) begin
            m_st = 0; m_ticks = 0; m_strikes = 0; m_rt = 0;
        end else begin
            case (m_st)
                0: if (xfer_tmo) begin m_st = 2; m_rt = 0; end
                   else if (wait_req) begin m_st = 1; m_ticks = 0; end
                1: if (xfer_tmo) begin m_st = 2; m_rt = 0; end
                   else if (!bus_busy) m_st = 0;
                   else if (m_strikes > LIM) begin m_strikes = 0; m_st = 2; m_rt = 0; end
                   else if (tick) begin
                       m_ticks++;
                       if (m_ticks == WT) begin err_n = 1; m_strikes++; m_st = 0; end
                   end
                default: begin
                    m_rt++;
                    if (m_rt > REC_LAST) m_st = 0;
                end
            endcase
        end
        m_err = err_n;
        started = 1;
        #1;
        tick_div = (tick_div + 1) % 3;
        tick = (tick_div == 2);
    end

    task automatic check(string t, logic act, logic exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0b expected=%0b at %0t", t, what, act, exp, $time);
        end
    endtask

    task automatic check_int(string t, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", t, what, act, exp);
        end
    endtask

    // per-cycle comparison and pulse monitor
    int err_cnt = 0, rec_cnt = 0, rises = 0, run = 0, bad_run = 0;
    bit p_sel = 0, p_lvl = 1;
    always @(negedge clk) begin
        if (started) begin
            bit e_sel, e_lvl, e_nack, e_rst;
            e_sel  = (m_st == 2) && m_rt >= 1 && m_rt <= 2 * P * N;
            e_lvl  = e_sel ? (((m_rt - 1) / P) % 2 == 0) : 1'b1;
            e_nack = (m_st == 2) && m_rt <= 2 * P * N;
            e_rst  = (m_st == 2) && m_rt == REC_LAST;
            check(tag, scl_manual_sel, e_sel, "scl_manual_sel");
            check(tag, scl_level, e_lvl, "scl_level");
            check(tag, nack_mode, e_nack, "nack_mode");
            check(tag, ctrl_reset, e_rst, "ctrl_reset");
            check(tag, done, e_rst, "done");
            check(tag, tmo_err, m_err, "tmo_err");
            if (!rst) begin
                if (tmo_err) err_cnt++;
                if (scl_manual_sel && scl_level && !(p_sel && p_lvl)) rises++;
                if (scl_manual_sel && p_sel && scl_level == p_lvl) run++;
                else begin
                    if (p_sel && run != P) bad_run++;
                    run = 1;
                end
                if (done) begin
                    rec_cnt++;
                    check_int("R6", rises, N, "pulse count");
                    check_int("R10", bad_run, 0, "phases not PHASE_CYCLES long");
                    rises = 0; bad_run = 0;
                end
            end
            p_sel = scl_manual_sel;
            p_lvl = scl_level;
        end
    end

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic pulse_req();
        wait_req = 1; cyc(1); wait_req = 0;
    endtask

    task automatic pulse_xfer();
        xfer_tmo = 1; cyc(1); xfer_tmo = 0;
    endtask

    initial begin
        int wd;
        for (wd = 0; wd < 150000; wd++) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        tag = "R1";
        cyc(4);
        rst = 0;
        cyc(3);
        tag = "R2";
        bus_busy = 0; pulse_req(); cyc(10);
        check_int("R2", err_cnt, 0, "errors with free bus");
        tag = "R3";
        bus_busy = 1;
        for (int i = 0; i < 3; i++) begin pulse_req(); cyc(25); end
        check_int("R3", err_cnt, 3, "reported timeouts");
        check_int("R3", rec_cnt, 0, "recoveries before escalation");
        tag = "R4";
        pulse_req(); cyc(5);
        tag = "R9";
        pulse_req(); cyc(20); pulse_xfer(); cyc(90);
        check_int("R4", rec_cnt, 1, "escalated recovery");
        cyc(30);
        check_int("R9", err_cnt, 3, "requests during recovery ignored");
        check_int("R9", rec_cnt, 1, "no extra recovery");
        tag = "R4";
        pulse_req(); cyc(25);
        check_int("R4", err_cnt, 4, "strike count cleared");
        tag = "R8";
        pulse_xfer(); cyc(110);
        check_int("R8", rec_cnt, 2, "transfer timeout recovery from idle");
        check_int("R8", err_cnt, 4, "no error on transfer timeout");
        for (int i = 0; i < 2; i++) begin pulse_req(); cyc(25); end
        check_int("R8", err_cnt, 6, "strikes kept across transfer timeout");
        pulse_req(); cyc(110);
        check_int("R8", rec_cnt, 3, "escalation after kept strikes");
        pulse_req(); cyc(3); pulse_xfer(); cyc(110);
        check_int("R8", rec_cnt, 4, "transfer timeout during wait");
        check_int("R8", err_cnt, 6, "no error from wait cut by transfer timeout");
        tag = "R2";
        pulse_req(); cyc(3); bus_busy = 0; cyc(20);
        check_int("R2", err_cnt, 6, "bus freed during wait");
        check_int("R2", rec_cnt, 4, "no recovery when bus freed");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule